// File: doc/BRIEF.md
# Spectral Bin Power Averager with Peak Hold

This block sits behind a transform engine that delivers 256 complex spectrum bins per transform, for four channels side by side, one bin position per accepted cycle. For every bin of every channel it forms the bin power, sums that power over a set of transform blocks, and keeps the largest power seen in the set together with the block number that produced it.

The number of blocks in a set is a power of two chosen on a configuration input. When the final bin of the final block has been taken in, the block stops accepting input and streams a result frame toward a memory writer, one 32-bit word per handshake, each word tagged with its word address. For each channel the frame holds one average word per bin and then one peak word per bin. After the last word is taken, a new set begins and owes nothing to the previous one.

Top module: `spectral_power_acc`

## Requirements
- R1: The power of a bin is re*re + im*im, with re and im signed 16-bit values; channel c takes its real part from in_re[16c+15:16c] and its imaginary part from in_im[16c+15:16c].
- R2: A set spans 2^k transform blocks, where k is cfg_blocks_log2 sampled together with the first accepted sample of the set; a k above 8 is treated as 8. A sample is accepted on a rising clock edge with in_valid and in_ready both high, and the samples of a block arrive in bin order 0 to 255.
- R3: An average word is the sum of the bin's powers over the set shifted right by k, keeping the low 32 bits.
- R4: A peak word carries in bits [23:0] the largest bin power of the set, saturated to 0xFFFFFF, and in bits [31:24] the 0-based number within the set of the block that produced it.
- R5: Peaks are compared on the saturated 24-bit value; when a later block only equals the held peak, the earlier block number is kept.
- R6: The results of a set depend only on the samples of that set; nothing carries over from an earlier set or from samples cut off by reset.
- R7: Two clock edges after the last sample of a set is accepted, out_valid rises and the frame follows: 2048 words at out_addr 0 to 2047 in increasing order, where out_addr = 512*channel + 256*(1 for a peak word, 0 for an average word) + bin.
- R8: in_ready is low from the edge that accepts the last sample of a set until the edge that takes the last frame word; in_valid is ignored during that time.
- R9: While out_valid is high and out_ready is low, out_valid, out_addr and out_data stay unchanged.
- R10: A synchronous active-low reset makes in_ready high and out_valid low and starts a new set at block 0, bin 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_blocks_log2 | input | 4 | Base-2 log of the blocks per set |
| in_valid | input | 1 | A bin position is offered on in_re / in_im |
| in_ready | output | 1 | The block takes a bin position this cycle |
| in_re | input | 64 | Real parts, 16 bits per channel |
| in_im | input | 64 | Imaginary parts, 16 bits per channel |
| out_valid | output | 1 | A frame word is offered |
| out_ready | input | 1 | The receiver takes the offered word |
| out_addr | output | 11 | Word address within the frame |
| out_data | output | 32 | Average or peak word |

## Verification
The assertions watch the frame handshake on every cycle: input held off while a frame is pending, words and addresses frozen under backpressure, the frame opening at address 0 and advancing by one per transfer, and the idle state after reset. The arithmetic (squaring of negative extremes, the shifted average across set sizes, saturation of the peak field, the tie rule and the block number packed beside a peak) together with the independence of consecutive sets and recovery from a reset in mid-set can only be shown by the bench scenarios, which compare every frame word against a model of the requirements.

// File: rtl/spa_pkg.sv
// Package: shared constants and the sequencer state type for the
// spectral power accumulator. Assumes 32-bit result words.
package spa_pkg;
    localparam int WORD_W = 32;   // result word width
    localparam int PK_W   = 24;   // peak power field width
    localparam int IDX_W  = 8;    // block number field width

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,  // taking in spectrum samples
        ST_FLUSH = 2'd1,  // last sample passing the pipeline
        ST_DRAIN = 2'd2   // streaming the result frame
    } seq_state_t;
endpackage

// File: rtl/spa_bin_power.sv
// Module: squares one complex bin and sums the two squares.
// Assumes signed two's-complement inputs; the result is unsigned and
// 2*SAMPLE_W bits wide, enough for (-2^(W-1))^2 * 2.
module spa_bin_power #(
    parameter int SAMPLE_W = 16
) (
    input  logic signed [SAMPLE_W-1:0]   re,
    input  logic signed [SAMPLE_W-1:0]   im,
    output logic        [2*SAMPLE_W-1:0] power
);
    localparam int PWR_W = 2 * SAMPLE_W;

    logic signed [PWR_W-1:0] re_x, im_x, re_sq, im_sq;

    // Sign-extend, square and add
    always_comb begin
        re_x  = {{SAMPLE_W{re[SAMPLE_W-1]}}, re};
        im_x  = {{SAMPLE_W{im[SAMPLE_W-1]}}, im};
        re_sq = re_x * re_x;
        im_sq = im_x * im_x;
        power = $unsigned(re_sq) + $unsigned(im_sq);
    end
endmodule

// File: rtl/spa_bin_store.sv
// Module: per-channel storage of running sums and peaks, one entry per
// bin. A write in the first block of a set overwrites the entry, so no
// clearing pass is needed. Assumes a bin is never written in two
// consecutive cycles.
module spa_bin_store #(
    parameter int NUM_BINS = 256,
    parameter int PWR_W    = 32,
    parameter int ACC_W    = 40,
    parameter int BLK_W    = 8
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_BINS)-1:0] wr_bin,
    input  logic                        wr_first,
    input  logic [BLK_W-1:0]            wr_blk,
    input  logic [PWR_W-1:0]            wr_power,
    input  logic [$clog2(NUM_BINS)-1:0] rd_bin,
    output logic [ACC_W-1:0]            rd_sum,
    output logic [spa_pkg::WORD_W-1:0]  rd_peak
);
    import spa_pkg::*;

    localparam logic [PWR_W-1:0] SAT_MAX = PWR_W'((64'd1 << PK_W) - 1);

    logic [ACC_W-1:0]      sum_mem  [NUM_BINS];
    logic [IDX_W+PK_W-1:0] peak_mem [NUM_BINS];
    logic [PK_W-1:0]       sat_pwr;
    logic [PK_W-1:0]       held_pwr;
    logic                  take_peak;

    // Saturate the new power and compare with the held peak
    always_comb begin
        sat_pwr   = (wr_power > SAT_MAX) ? PK_W'(SAT_MAX) : wr_power[PK_W-1:0];
        held_pwr  = peak_mem[wr_bin][PK_W-1:0];
        take_peak = wr_first || (sat_pwr > held_pwr);
    end

    // Read-modify-write of sum and peak for the incoming bin
    always_ff @(posedge clk) begin
        if (wr_en) begin
            sum_mem[wr_bin] <= wr_first ? ACC_W'(wr_power)
                                        : sum_mem[wr_bin] + ACC_W'(wr_power);
            if (take_peak)
                peak_mem[wr_bin] <= {IDX_W'(wr_blk), sat_pwr};
        end
    end

    // Drain-side read port
    assign rd_sum  = sum_mem[rd_bin];
    assign rd_peak = WORD_W'(peak_mem[rd_bin]);
endmodule

// File: rtl/spa_set_seq.sv
// Module: counts bins and blocks of a set, holds off input while the
// result frame drains, and walks the frame address. Assumes NUM_BINS
// and NUM_CH are powers of two and MAX_LOG2 is at most 8.
module spa_set_seq #(
    parameter int NUM_BINS = 256,
    parameter int MAX_LOG2 = 8,
    parameter int ADDR_W   = 11
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [$clog2(MAX_LOG2+1)-1:0]   cfg_log2,
    input  logic                            in_valid,
    output logic                            in_ready,
    output logic                            fire,
    output logic [$clog2(NUM_BINS)-1:0]     cur_bin,
    output logic [MAX_LOG2-1:0]             cur_blk,
    output logic                            cur_first,
    input  logic                            out_ready,
    output logic                            drain_valid,
    output logic [ADDR_W-1:0]               rd_addr,
    output logic [$clog2(MAX_LOG2+1)-1:0]   set_log2
);
    import spa_pkg::*;

    localparam int BIN_W  = $clog2(NUM_BINS);
    localparam int LOG2_W = $clog2(MAX_LOG2 + 1);

    seq_state_t          state;
    logic [BIN_W-1:0]    bin_cnt;
    logic [MAX_LOG2-1:0] blk_cnt;
    logic [LOG2_W-1:0]   log2_q;
    logic [LOG2_W-1:0]   cfg_clamp, eff_log2;
    logic [MAX_LOG2:0]   span;
    logic                set_start, last_bin, last_blk;

    // Decode the current position within the set
    always_comb begin
        cfg_clamp = (cfg_log2 > LOG2_W'(MAX_LOG2)) ? LOG2_W'(MAX_LOG2) : cfg_log2;
        set_start = (bin_cnt == '0) && (blk_cnt == '0);
        eff_log2  = set_start ? cfg_clamp : log2_q;
        span      = (MAX_LOG2+1)'(1) << eff_log2;
        last_bin  = (bin_cnt == BIN_W'(NUM_BINS - 1));
        last_blk  = ({1'b0, blk_cnt} == span - 1'b1);
    end

    assign in_ready    = (state == ST_FILL);
    assign fire        = in_valid && in_ready;
    assign cur_bin     = bin_cnt;
    assign cur_blk     = blk_cnt;
    assign cur_first   = (blk_cnt == '0);
    assign drain_valid = (state == ST_DRAIN);
    assign set_log2    = log2_q;

    // State, counters and frame address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_FILL;
            bin_cnt <= '0;
            blk_cnt <= '0;
            log2_q  <= '0;
            rd_addr <= '0;
        end else begin
            case (state)
                ST_FILL: if (fire) begin
                    if (set_start) log2_q <= cfg_clamp;
                    if (last_bin) begin
                        bin_cnt <= '0;
                        if (last_blk) begin
                            blk_cnt <= '0;
                            state   <= ST_FLUSH;
                        end else begin
                            blk_cnt <= blk_cnt + 1'b1;
                        end
                    end else begin
                        bin_cnt <= bin_cnt + 1'b1;
                    end
                end
                ST_FLUSH: begin
                    rd_addr <= '0;
                    state   <= ST_DRAIN;
                end
                default: if (out_ready) begin
                    rd_addr <= rd_addr + 1'b1;
                    if (&rd_addr) state <= ST_FILL;
                end
            endcase
        end
    end
endmodule

// File: rtl/spectral_power_acc.sv
// Module: top of the per-bin average and peak power accumulator. One
// pipeline stage squares the bins, the next updates per-channel stores;
// at the end of a set the frame of averages and peaks is streamed out.
// Assumes NUM_CH and NUM_BINS are powers of two, NUM_CH >= 2.
module spectral_power_acc #(
    parameter int NUM_CH   = 4,
    parameter int NUM_BINS = 256,
    parameter int SAMPLE_W = 16,
    parameter int MAX_LOG2 = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [$clog2(MAX_LOG2+1)-1:0]  cfg_blocks_log2,
    input  logic                           in_valid,
    output logic                           in_ready,
    input  logic [NUM_CH*SAMPLE_W-1:0]     in_re,
    input  logic [NUM_CH*SAMPLE_W-1:0]     in_im,
    output logic                           out_valid,
    input  logic                           out_ready,
    output logic [$clog2(NUM_CH)+$clog2(NUM_BINS):0] out_addr,
    output logic [spa_pkg::WORD_W-1:0]     out_data
);
    import spa_pkg::*;

    localparam int BIN_W  = $clog2(NUM_BINS);
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int ADDR_W = CH_W + BIN_W + 1;
    localparam int LOG2_W = $clog2(MAX_LOG2 + 1);
    localparam int PWR_W  = 2 * SAMPLE_W;
    localparam int ACC_W  = PWR_W + MAX_LOG2;

    logic                fire, cur_first, p1_valid, p1_first;
    logic [BIN_W-1:0]    cur_bin, p1_bin;
    logic [MAX_LOG2-1:0] cur_blk, p1_blk;
    logic [LOG2_W-1:0]   set_log2;
    logic [ADDR_W-1:0]   rd_addr;
    logic [WORD_W-1:0]   avg_word [NUM_CH];
    logic [WORD_W-1:0]   peak_word [NUM_CH];

    spa_set_seq #(
        .NUM_BINS (NUM_BINS),
        .MAX_LOG2 (MAX_LOG2),
        .ADDR_W   (ADDR_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_log2    (cfg_blocks_log2),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .fire        (fire),
        .cur_bin     (cur_bin),
        .cur_blk     (cur_blk),
        .cur_first   (cur_first),
        .out_ready   (out_ready),
        .drain_valid (out_valid),
        .rd_addr     (rd_addr),
        .set_log2    (set_log2)
    );

    // Stage-one control: position of the bin being squared
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p1_valid <= 1'b0;
            p1_first <= 1'b0;
            p1_bin   <= '0;
            p1_blk   <= '0;
        end else begin
            p1_valid <= fire;
            if (fire) begin
                p1_first <= cur_first;
                p1_bin   <= cur_bin;
                p1_blk   <= cur_blk;
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        logic [PWR_W-1:0] pwr_now, pwr_q;
        logic [ACC_W-1:0] sum_rd, sum_shift;

        spa_bin_power #(.SAMPLE_W(SAMPLE_W)) u_pwr (
            .re    (in_re[c*SAMPLE_W +: SAMPLE_W]),
            .im    (in_im[c*SAMPLE_W +: SAMPLE_W]),
            .power (pwr_now)
        );

        // Stage-one register of this lane's power
        always_ff @(posedge clk) begin
            if (!rst_n)    pwr_q <= '0;
            else if (fire) pwr_q <= pwr_now;
        end

        spa_bin_store #(
            .NUM_BINS (NUM_BINS),
            .PWR_W    (PWR_W),
            .ACC_W    (ACC_W),
            .BLK_W    (MAX_LOG2)
        ) u_store (
            .clk      (clk),
            .wr_en    (p1_valid),
            .wr_bin   (p1_bin),
            .wr_first (p1_first),
            .wr_blk   (p1_blk),
            .wr_power (pwr_q),
            .rd_bin   (rd_addr[BIN_W-1:0]),
            .rd_sum   (sum_rd),
            .rd_peak  (peak_word[c])
        );

        assign sum_shift   = sum_rd >> set_log2;
        assign avg_word[c] = sum_shift[WORD_W-1:0];
    end

    // Frame word select: channel from the top bits, kind from bit BIN_W
    assign out_addr = rd_addr;
    assign out_data = rd_addr[BIN_W] ? peak_word[rd_addr[ADDR_W-1 -: CH_W]]
                                     : avg_word[rd_addr[ADDR_W-1 -: CH_W]];
endmodule

// File: rtl/spa_checker.sv
// Module: protocol checker for the result frame and input hold-off,
// bound into spectral_power_acc. Assumes the frame starts at address 0.
module spa_checker #(
    parameter int OUT_AW = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [OUT_AW-1:0] out_addr,
    input logic [31:0]       out_data
);
    logic rst_seen = 1'b0;

    // Remember that the previous edge saw reset
    always_ff @(posedge clk) rst_seen <= !rst_n;

    AST_HOLD_OFF_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);  // R8

    AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data)));  // R9

    AST_FRAME_OPENS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_addr == '0));  // R7

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !(&out_addr)) |=> (out_valid && out_addr == $past(out_addr) + 1'b1));  // R7

    AST_FRAME_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && (&out_addr)) |=> (!out_valid && in_ready));  // R8

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst_seen |-> (in_ready && !out_valid));  // R10
endmodule

bind spectral_power_acc spa_checker #(.OUT_AW(ADDR_W)) i_spa_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_data  (out_data)
);

// File: tb/test_spectral_power_acc.sv
// Bench: walks a table of set scenarios, models each set from the
// requirements, and compares every frame word; then directed tests.
module test_spectral_power_acc;
    localparam int NCH   = 4;
    localparam int NBIN  = 256;
    localparam int FRAME = 2 * NCH * NBIN;

    // Vector fields: [15:12] cfg log2, [11:10] pattern, [9:6] input gap,
    // [5:2] output stall period, [0] drive junk during drain
    localparam int NVEC = 6;
    localparam logic [15:0] VECS [NVEC] = '{
        {4'd0, 2'd0, 4'd0, 4'd0, 2'b00},
        {4'd2, 2'd0, 4'd3, 4'd2, 2'b01},
        {4'd1, 2'd1, 4'd0, 4'd0, 2'b00},
        {4'd1, 2'd2, 4'd0, 4'd3, 2'b00},
        {4'd3, 2'd0, 4'd5, 4'd0, 2'b01},
        {4'd9, 2'd0, 4'd0, 4'd0, 2'b00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_blocks_log2 = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_re = '0;
    logic [63:0] in_im = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [10:0] out_addr;
    logic [31:0] out_data;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    bit  done = 1'b0;

    longint exp_sum [NCH*NBIN];
    longint exp_pk  [NCH*NBIN];
    int     exp_idx [NCH*NBIN];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spectral_power_acc i_spectral_power_acc (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_blocks_log2 (cfg_blocks_log2),
        .in_valid        (in_valid),
        .in_ready        (in_ready),
        .in_re           (in_re),
        .in_im           (in_im),
        .out_valid       (out_valid),
        .out_ready       (out_ready),
        .out_addr        (out_addr),
        .out_data        (out_data)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic void gen(input int mode, input int seed, input int ch,
                                input int bin, input int blk,
                                output logic signed [15:0] re,
                                output logic signed [15:0] im);
        case (mode)
            0: begin
                re = 16'((bin*37 + ch*1009 + blk*523 + seed*71) % 4096 - 2048);
                im = 16'((bin*11 + blk*97 + ch*5 + seed) % 2048 - 1024);
            end
            1: begin  // identical every block: peak ties (R5)
                re = 16'(bin - 128);
                im = 16'(ch*100 - seed);
            end
            default: begin  // extremes: squaring of -32768 (R1), saturation (R4)
                re = 16'sh8000;
                im = (blk % 2 == 1) ? 16'sh8000 : 16'sh7FFF;
            end
        endcase
    endfunction

    // Feed one full set, then collect and compare the frame
    task automatic run_set(input int log2, input int mode, input int gap,
                           input int stall, input bit junk, input int seed);
        int eff, nblk, k, cnt;
        bit held_v;
        logic [10:0] held_a;
        logic [31:0] held_d;
        eff  = (log2 > 8) ? 8 : log2;
        nblk = 1 << eff;
        cnt  = 0;
        cfg_blocks_log2 = 4'(log2);
        for (int blk = 0; blk < nblk; blk++) begin
            for (int bin = 0; bin < NBIN; bin++) begin
                @(negedge clk);
                if (gap != 0 && (cnt % gap) == gap - 1) begin
                    in_valid = 1'b0;
                    @(negedge clk);
                end
                cnt++;
                for (int ch = 0; ch < NCH; ch++) begin
                    logic signed [15:0] re, im;
                    longint p, s;
                    int e;
                    gen(mode, seed, ch, bin, blk, re, im);
                    in_re[ch*16 +: 16] = re;
                    in_im[ch*16 +: 16] = im;
                    e = ch*NBIN + bin;
                    p = longint'(re)*longint'(re) + longint'(im)*longint'(im);
                    s = (p > 64'hFFFFFF) ? 64'hFFFFFF : p;
                    if (blk == 0) begin
                        exp_sum[e] = p;
                        exp_pk[e]  = s;
                        exp_idx[e] = 0;
                    end else begin
                        exp_sum[e] += p;
                        if (s > exp_pk[e]) begin
                            exp_pk[e]  = s;
                            exp_idx[e] = blk;
                        end
                    end
                end
                in_valid = 1'b1;
                while (!in_ready) @(negedge clk);
            end
        end
        // After the accepting edge: still flushing (R7), input held off (R8)
        @(negedge clk);
        in_valid = junk;
        in_re = {$urandom, $urandom};
        in_im = {$urandom, $urandom};
        chk(!out_valid, "R7", "out_valid one edge after last sample", out_valid, 0);
        chk(!in_ready, "R8", "in_ready after last sample", in_ready, 0);
        k = 0;
        held_v = 1'b0;
        held_a = '0;
        held_d = '0;
        while (k < FRAME) begin
            @(negedge clk);
            if (k == 0)
                chk(out_valid, "R7", "out_valid two edges after last sample", out_valid, 1);
            if (held_v) begin
                chk(out_valid && out_addr == held_a && out_data == held_d, "R9",
                    "word held under stall", {out_addr, out_data}, {held_a, held_d});
                held_v = 1'b0;
            end
            out_ready = (stall == 0) || (cyc % stall != 0);
            if (junk) begin
                in_re = {$urandom, $urandom};
                in_im = {$urandom, $urandom};
            end
            if (out_valid && out_ready) begin
                int ch, bin, e;
                longint ev;
                string tag;
                bit pk;
                ch  = k / (2*NBIN);
                pk  = ((k / NBIN) % 2) == 1;
                bin = k % NBIN;
                e   = ch*NBIN + bin;
                chk(out_addr == 11'(k), "R7", "frame address", out_addr, k);
                if (k == 0) chk(!in_ready, "R8", "in_ready during drain", in_ready, 0);
                if (pk) begin
                    ev  = (longint'(exp_idx[e]) << 24) | exp_pk[e];
                    tag = (mode == 1) ? "R5" : "R4";
                end else begin
                    ev  = (exp_sum[e] >> eff) & 64'hFFFFFFFF;
                    tag = (log2 > 8) ? "R2" : ((mode == 2) ? "R1" : "R3");
                end
                chk(out_data == 32'(ev), tag, $sformatf("word %0d", k), out_data, ev);
                k++;
            end else if (out_valid) begin
                held_v = 1'b1;
                held_a = out_addr;
                held_d = out_data;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b0;
        chk(in_ready && !out_valid, "R8", "ready again after frame",
            {in_ready, out_valid}, 2'b10);
    endtask

    initial begin
        // R10: reset state
        repeat (2) @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R10", "reset state",
            {in_ready, out_valid}, 2'b10);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk; later sets also show R6 (no carry-over between sets)
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] w;
            w = VECS[v];
            run_set(int'(w[15:12]), int'(w[11:10]), int'(w[9:6]),
                    int'(w[5:2]), w[0], v);
        end

        // Directed: reset in the middle of a set (R6, R10)
        cfg_blocks_log2 = 4'd1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_re = {$urandom, $urandom};
            in_im = {$urandom, $urandom};
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R10", "reset mid-set",
            {in_ready, out_valid}, 2'b10);
        @(negedge clk);
        rst_n = 1'b1;
        // A one-block set after reset must drain after exactly 256 samples
        run_set(0, 0, 0, 0, 1'b0, 17);
        // R6: a new set right after a junk-driven drain
        run_set(1, 0, 2, 2, 1'b1, 23);
        run_set(0, 2, 0, 0, 1'b0, 5);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule